// File: doc/BRIEF.md
# Transmit Collision Tally

This block counts the collisions that one transmit attempt runs into and shows the total in the low four bits of an 8-bit readable register. It also produces two status flags. The collision-seen flag reports that the attempt met at least one collision. The aborted flag reports that the attempt was given up because of excessive collisions.

A transmit-start command opens an attempt and clears the count and both flags. While the attempt is open, each collision strobe adds one to the count. A transmit-done strobe closes the attempt and keeps the count. An excessive-collision abort strobe, or the sixteenth collision, also closes the attempt: it sets the aborted flag and forces the count back to zero. Reading the register leaves it unchanged. The value holds until the next transmit-start command. All outputs are registered and change on the clock edge that samples the input causing the change.

Top module: `txcoll_tally`

## Requirements
- R1: After reset the register reads 0x00, and the collision-seen and aborted flags are both 0.
- R2: Each collision strobe inside an open attempt raises the count field by exactly one on the next clock edge, up to 15.
- R3: An attempt that closes through transmit-done with no collision leaves the count at 0 and collision-seen at 0.
- R4: Collision-seen goes to 1 on the edge that samples the first collision of an attempt and stays at 1 until the next transmit-start.
- R5: Transmit-start clears the count and both flags on the next edge and opens an attempt. It has priority over every other input in the same cycle, so a collision in that cycle is not counted.
- R6: An abort strobe inside an open attempt sets the aborted flag, forces the count to 0 and closes the attempt.
- R7: The sixteenth collision of an attempt sets the aborted flag, forces the count to 0 and closes the attempt.
- R8: When no attempt is open, collision, done and abort strobes change neither the count nor the flags.
- R9: Bits 7:4 of the register always read 0. The count sits in bits 3:0 as an unsigned binary value.
- R10: After transmit-done, the count and collision-seen hold their values until the next transmit-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_start_i | input | 1 | Transmit-start command; opens an attempt |
| coll_i | input | 1 | One-cycle collision event strobe |
| tx_done_i | input | 1 | Transmit-done strobe; closes the attempt |
| xs_abort_i | input | 1 | Excessive-collision abort strobe |
| count_o | output | 8 | Register value; bits 3:0 hold the collision count, bits 7:4 are zero |
| col_seen_o | output | 1 | At least one collision occurred in this attempt |
| aborted_o | output | 1 | The attempt was aborted on excessive collisions |

## Verification
Every result is due exactly one clock edge after the cycle in which its stimulus is presented, because the count, both flags and the attempt state are each a single register stage. The driver applies one input vector on the falling edge. It then queues the values that a requirement-level model predicts for the following rising edge. The monitor pops that entry shortly after the rising edge and compares it, so each comparison lines up with the single edge the stimulus acts on. Vectors are aimed at priority collisions, such as start together with a collision, and at the 15/16 boundary.

// File: rtl/txcoll_pkg.sv
package txcoll_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } att_state_e;
endpackage

// File: rtl/txcoll_attempt.sv
module txcoll_attempt
  import txcoll_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_start_i,
  input  logic tx_done_i,
  input  logic abort_evt_i,
  output logic busy_o
);
  att_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (tx_start_i) begin
      state_d = ST_BUSY;
    end else if (state_q == ST_BUSY && (tx_done_i || abort_evt_i)) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == ST_BUSY);
endmodule

// File: rtl/txcoll_counter.sv
module txcoll_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_start_i,
  input  logic             coll_i,
  input  logic             xs_abort_i,
  input  logic             busy_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             abort_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             xs_hit;

  // Next collision beyond the largest representable count is the excessive one
  assign xs_hit      = busy_i && coll_i && (cnt_q == CNT_MAX);
  assign abort_evt_o = busy_i && (xs_abort_i || xs_hit);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (tx_start_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (abort_evt_o) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (busy_i && coll_i && cnt_q != CNT_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/txcoll_status.sv
module txcoll_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_start_i,
  input  logic coll_i,
  input  logic busy_i,
  input  logic abort_evt_i,
  output logic col_o,
  output logic abt_o
);
  logic col_q, col_d, abt_q, abt_d;

  always_comb begin
    col_d = col_q;
    abt_d = abt_q;
    if (tx_start_i) begin
      col_d = 1'b0;
      abt_d = 1'b0;
    end else if (busy_i) begin
      if (coll_i)      col_d = 1'b1;
      if (abort_evt_i) abt_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= 1'b0;
      abt_q <= 1'b0;
    end else begin
      col_q <= col_d;
      abt_q <= abt_d;
    end
  end

  assign col_o = col_q;
  assign abt_o = abt_q;
endmodule

// File: rtl/txcoll_tally.sv
module txcoll_tally #(
  parameter int CNT_W = 4,
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_start_i,
  input  logic             coll_i,
  input  logic             tx_done_i,
  input  logic             xs_abort_i,
  output logic [REG_W-1:0] count_o,
  output logic             col_seen_o,
  output logic             aborted_o
);
  localparam int PAD_W = REG_W - CNT_W;

  logic             attempt_busy;
  logic             abort_evt;
  logic [CNT_W-1:0] cnt;

  txcoll_attempt u_attempt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_start_i (tx_start_i),
    .tx_done_i  (tx_done_i),
    .abort_evt_i(abort_evt),
    .busy_o     (attempt_busy)
  );

  txcoll_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_start_i (tx_start_i),
    .coll_i     (coll_i),
    .xs_abort_i (xs_abort_i),
    .busy_i     (attempt_busy),
    .cnt_o      (cnt),
    .abort_evt_o(abort_evt)
  );

  txcoll_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_start_i (tx_start_i),
    .coll_i     (coll_i),
    .busy_i     (attempt_busy),
    .abort_evt_i(abort_evt),
    .col_o      (col_seen_o),
    .abt_o      (aborted_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign count_o = {{PAD_W{1'b0}}, cnt};
    end else begin : g_nopad
      assign count_o = cnt;
    end
  endgenerate
endmodule

// File: rtl/txcoll_tally_chk.sv
module txcoll_tally_chk #(
  parameter int CNT_W = 4,
  parameter int REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_start_i,
  input logic             coll_i,
  input logic             tx_done_i,
  input logic             xs_abort_i,
  input logic [REG_W-1:0] count_o,
  input logic             col_seen_o,
  input logic             aborted_o,
  input logic             busy_i
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R9
  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o[REG_W-1:CNT_W] == '0);

  // R2
  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && coll_i && !tx_start_i && !xs_abort_i && count_o[CNT_W-1:0] != CMAX
    |=> count_o[CNT_W-1:0] == $past(count_o[CNT_W-1:0]) + CNT_W'(1));

  // R5
  a_r5_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |=> count_o == '0 && !col_seen_o && !aborted_o && busy_i);

  // R6
  a_r6_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && xs_abort_i && !tx_start_i |=> aborted_o && count_o == '0 && !busy_i);

  // R7
  a_r7_sixteenth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && coll_i && !tx_start_i && count_o[CNT_W-1:0] == CMAX
    |=> aborted_o && count_o == '0 && !busy_i);

  // R8
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !tx_start_i |=> $stable(count_o) && $stable(col_seen_o) && $stable(aborted_o));

  // R10
  a_r10_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && tx_done_i && !coll_i && !xs_abort_i && !tx_start_i
    |=> $stable(count_o) && !busy_i);

  // R4
  a_r4_col_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_seen_o) |-> $past(coll_i) && $past(busy_i));
endmodule

bind txcoll_tally txcoll_tally_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_start_i(tx_start_i),
  .coll_i    (coll_i),
  .tx_done_i (tx_done_i),
  .xs_abort_i(xs_abort_i),
  .count_o   (count_o),
  .col_seen_o(col_seen_o),
  .aborted_o (aborted_o),
  .busy_i    (attempt_busy)
);

// File: tb/txcoll_tally_tb.sv
module txcoll_tally_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tx_start_i, coll_i, tx_done_i, xs_abort_i;
  logic [7:0] count_o;
  logic       col_seen_o, aborted_o;

  int checks = 0;
  int fails  = 0;
  bit done_all = 0;

  typedef struct {
    logic [7:0] cnt;
    logic       col;
    logic       abt;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  // requirement-level model state
  int m_cnt;
  bit m_col, m_abt, m_busy;

  always #5 clk_i = ~clk_i;

  txcoll_tally dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_start_i(tx_start_i), .coll_i(coll_i),
    .tx_done_i(tx_done_i), .xs_abort_i(xs_abort_i), .count_o(count_o),
    .col_seen_o(col_seen_o), .aborted_o(aborted_o)
  );

  task automatic step(input bit s, input bit c, input bit d, input bit a, input string tag);
    exp_t e;
    @(negedge clk_i);
    tx_start_i = s; coll_i = c; tx_done_i = d; xs_abort_i = a;
    if (s) begin
      m_cnt = 0; m_col = 0; m_abt = 0; m_busy = 1;
    end else if (m_busy) begin
      bit xs;
      xs = 0;
      if (c) begin
        m_col = 1;
        if (m_cnt == 15) xs = 1; else m_cnt++;
      end
      if (a || xs) begin
        m_abt = 1; m_cnt = 0; m_busy = 0;
      end else if (d) begin
        m_busy = 0;
      end
    end
    e.cnt = 8'(m_cnt); e.col = m_col; e.abt = m_abt; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (count_o !== e.cnt || col_seen_o !== e.col || aborted_o !== e.abt) begin
          fails++;
          $display("FAIL %s: got cnt=%0d col=%0b abt=%0b exp cnt=%0d col=%0b abt=%0b",
                   e.tag, count_o, col_seen_o, aborted_o, e.cnt, e.col, e.abt);
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (!done_all && wd < 5000) begin
      @(posedge clk_i);
      wd++;
    end
    if (!done_all) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tx_start_i = 0; coll_i = 0; tx_done_i = 0; xs_abort_i = 0;
    m_cnt = 0; m_col = 0; m_abt = 0; m_busy = 0;
    rst_ni = 0;
    repeat (3) @(posedge clk_i);
    #2;
    checks++;
    if (count_o !== 8'h00 || col_seen_o !== 1'b0 || aborted_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: got cnt=%0d col=%0b abt=%0b exp 0 0 0", count_o, col_seen_o, aborted_o);
    end
    @(negedge clk_i);
    rst_ni = 1;
    // R8 before any attempt: strobes ignored
    step(0, 1, 0, 0, "R8 idle coll");
    step(0, 0, 0, 1, "R8 idle abort");
    // R2 R4 R10
    step(1, 0, 0, 0, "R5 start");
    step(0, 1, 0, 0, "R4 first coll");
    step(0, 0, 0, 0, "R4 col holds");
    step(0, 1, 0, 0, "R2 second");
    step(0, 1, 0, 0, "R2 third");
    step(0, 0, 1, 0, "R10 done");
    step(0, 1, 0, 0, "R8 after done coll");
    step(0, 0, 0, 1, "R8 after done abort");
    step(0, 0, 0, 0, "R10 hold");
    // R3
    step(1, 0, 0, 0, "R5 clears");
    step(0, 0, 1, 0, "R3 clean done");
    step(0, 0, 0, 0, "R3 hold");
    // R5 start with collision in same cycle
    step(1, 1, 0, 0, "R5 start wins");
    step(0, 1, 1, 0, "R2 coll with done");
    // R6
    step(1, 0, 0, 0, "R5 restart");
    step(0, 1, 0, 0, "R2 coll");
    step(0, 1, 0, 0, "R2 coll");
    step(0, 0, 0, 1, "R6 abort");
    step(0, 1, 0, 0, "R8 after abort");
    step(1, 0, 0, 0, "R5 clears abt");
    // R7: sixteen collisions
    for (int i = 0; i < 15; i++) step(0, 1, 0, 0, "R2 climb");
    step(0, 1, 0, 0, "R7 sixteenth");
    step(0, 1, 0, 0, "R8 after xs");
    // R2 boundary: fifteen then done
    step(1, 0, 0, 0, "R5 restart");
    for (int i = 0; i < 15; i++) step(0, 1, 0, 0, "R9 R2 to fifteen");
    step(0, 0, 1, 0, "R10 done at 15");
    step(0, 0, 0, 0, "R10 hold 15");
    step(0, 0, 0, 0, "idle");
    repeat (3) @(posedge clk_i);
    #3;
    done_all = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule